// File: doc/BRIEF.md
# Five-Valued Gate Evaluator with Fault-Effect Propagation

This block evaluates one logic gate with a parameterised number of inputs for test pattern generation. Each input carries a value from a five-valued logic: plain 0 and 1, unknown X, and two fault-effect values. The first, E, is 1 in the good machine and 0 in the faulty machine. The second, E', is 0 in the good machine and 1 in the faulty machine. The gate type is selected at run time by two bits: the controlling value and the inversion bit.

The evaluator does not look the result up in a truth table. It scans all inputs for controlling values, unknowns and fault effects, and resolves the output from those summary flags. The block also raises a flag whenever a fault effect present on the inputs reaches the output. A test generator can use the block to decide whether a partial assignment lets an error reach the gate output.

An optional output register adds one cycle of latency. This register is on by default.

Top module: `dgate_eval`

## Requirements
- R1: Input and output values use 3-bit codes: 000 = 0, 001 = 1, 010 = X, 011 = E (good 1 / faulty 0), 100 = E' (good 0 / faulty 1). Codes 101, 110 and 111 on an input are evaluated exactly like X.
- R2: The gate type is given as (controlling value, inversion): AND = (0,0), OR = (1,0), NAND = (0,1), NOR = (1,1).
- R3: If any input holds the plain controlling value, the output is the controlling value XOR inversion, and the propagate flag is 0.
- R4: If every input holds the plain non-controlling value, the output is the non-controlling value XOR inversion.
- R5: Fault effects of a single kind pass through when every other input is non-controlling. The output is that fault value XOR inversion, so E leaves AND/OR as E and leaves NAND/NOR as E'. An AND or NAND needs its side inputs at 1; an OR or NOR needs them at 0.
- R6: If E and E' are both present on the inputs, the pair acts as a controlling value. The output is the controlling value XOR inversion, and the propagate flag is 0.
- R7: If no input is controlling (counting R6) and at least one input is X or an illegal code, the output is X.
- R8: The propagate flag is 1 exactly when the output code is E or E'.
- R9: With the output register enabled (default), the outputs reflect the inputs of the previous clock edge. During reset, the output code is 000 and the propagate flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_codes | input | N_IN*3 | Packed input values; input k occupies bits [3k+2:3k] |
| ctrl_val | input | 1 | Controlling value of the gate type |
| inv_bit | input | 1 | Inversion of the gate type |
| out_code | output | 3 | Five-valued gate output |
| prop | output | 1 | Fault effect reaches the output |

## Verification
The hardest situation to reach from the ports is the boundary between propagation and blocking. This covers a lone fault effect that meets a side input which is exactly non-controlling, X, or an illegal code. It also covers E meeting E' with no plain controlling input present. Random vectors over all eight codes rarely produce a clean propagation on four inputs. The stimulus therefore includes directed sweeps over all four gate types. These sweeps place one fault value among ideal side inputs and then spoil one side input at a time. A reference model that evaluates the good and faulty machines separately judges each vector on every clock.

// File: rtl/dgate_pkg.sv
package dgate_pkg;

  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    L_ZERO = 3'b000,
    L_ONE  = 3'b001,
    L_UNK  = 3'b010,
    L_ERR  = 3'b011,
    L_NERR = 3'b100
  } lvl_e;

  typedef struct packed {
    logic has_ctrl;
    logic has_unk;
    logic has_err;
    logic has_nerr;
  } scan_t;

  function automatic lvl_e plain_lvl(input logic b);
    return b ? L_ONE : L_ZERO;
  endfunction

endpackage

// File: rtl/dgate_decode.sv
module dgate_decode
  import dgate_pkg::*;
#(
  parameter int N_IN = 4,
  localparam int IN_W = N_IN * CODE_W
) (
  input  logic [IN_W-1:0] in_codes,
  output logic [N_IN-1:0] is_zero,
  output logic [N_IN-1:0] is_one,
  output logic [N_IN-1:0] is_unk,
  output logic [N_IN-1:0] is_err,
  output logic [N_IN-1:0] is_nerr
);

  for (genvar g = 0; g < N_IN; g++) begin : g_lane
    logic [CODE_W-1:0] code_w;
    assign code_w = in_codes[g*CODE_W +: CODE_W];

    always_comb begin
      is_zero[g] = 1'b0;
      is_one[g]  = 1'b0;
      is_unk[g]  = 1'b0;
      is_err[g]  = 1'b0;
      is_nerr[g] = 1'b0;
      case (code_w)
        L_ZERO:  is_zero[g] = 1'b1;
        L_ONE:   is_one[g]  = 1'b1;
        L_ERR:   is_err[g]  = 1'b1;
        L_NERR:  is_nerr[g] = 1'b1;
        default: is_unk[g]  = 1'b1;  // X and the three illegal codes
      endcase
    end

    // R1: each lane falls into exactly one value class
    always_comb begin
      if (!$isunknown(code_w))
        a_r1_one_class: assert ($onehot({is_zero[g], is_one[g], is_unk[g],
                                          is_err[g], is_nerr[g]}));
    end
  end

endmodule

// File: rtl/dgate_scan.sv
module dgate_scan
  import dgate_pkg::*;
#(
  parameter int N_IN = 4
) (
  input  logic [N_IN-1:0] is_zero,
  input  logic [N_IN-1:0] is_one,
  input  logic [N_IN-1:0] is_unk,
  input  logic [N_IN-1:0] is_err,
  input  logic [N_IN-1:0] is_nerr,
  input  logic            ctrl_val,
  output scan_t           scan
);

  logic [N_IN-1:0] ctrl_hit;

  // A lane is plainly controlling when it carries the controlling value.
  for (genvar g = 0; g < N_IN; g++) begin : g_hit
    assign ctrl_hit[g] = ctrl_val ? is_one[g] : is_zero[g];
  end

  always_comb begin
    scan.has_ctrl = |ctrl_hit;
    scan.has_unk  = |is_unk;
    scan.has_err  = |is_err;
    scan.has_nerr = |is_nerr;
  end

endmodule

// File: rtl/dgate_resolve.sv
module dgate_resolve
  import dgate_pkg::*;
(
  input  scan_t ctrl_scan,
  input  logic  ctrl_val,
  input  logic  inv_bit,
  output lvl_e  out_lvl,
  output logic  fault_pass
);

  logic clash;
  assign clash = ctrl_scan.has_err & ctrl_scan.has_nerr;

  always_comb begin
    out_lvl    = plain_lvl(~ctrl_val ^ inv_bit);
    fault_pass = 1'b0;
    if (ctrl_scan.has_ctrl || clash) begin
      out_lvl = plain_lvl(ctrl_val ^ inv_bit);
    end else if (ctrl_scan.has_unk) begin
      out_lvl = L_UNK;
    end else if (ctrl_scan.has_err) begin
      out_lvl    = inv_bit ? L_NERR : L_ERR;
      fault_pass = 1'b1;
    end else if (ctrl_scan.has_nerr) begin
      out_lvl    = inv_bit ? L_ERR : L_NERR;
      fault_pass = 1'b1;
    end
  end

  always_comb begin
    if (!$isunknown({ctrl_scan, ctrl_val, inv_bit})) begin
      // R6: opposite fault effects never reach the output
      if (clash) a_r6_clash_blocks: assert (!fault_pass);
      // R7: an unknown with no controlling input yields X
      if (!ctrl_scan.has_ctrl && !clash && ctrl_scan.has_unk)
        a_r7_unknown_out: assert (out_lvl == L_UNK);
    end
  end

endmodule

// File: rtl/dgate_eval.sv
module dgate_eval
  import dgate_pkg::*;
#(
  parameter int N_IN    = 4,
  parameter bit REG_OUT = 1'b1,
  localparam int IN_W   = N_IN * CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IN_W-1:0]   in_codes,
  input  logic              ctrl_val,
  input  logic              inv_bit,
  output logic [CODE_W-1:0] out_code,
  output logic              prop
);

  logic [N_IN-1:0] is_zero, is_one, is_unk, is_err, is_nerr;
  scan_t           scan;
  lvl_e            lvl_c;
  logic            pass_c;

  dgate_decode #(.N_IN(N_IN)) u_decode (
    .in_codes (in_codes),
    .is_zero  (is_zero),
    .is_one   (is_one),
    .is_unk   (is_unk),
    .is_err   (is_err),
    .is_nerr  (is_nerr)
  );

  dgate_scan #(.N_IN(N_IN)) u_scan (
    .is_zero  (is_zero),
    .is_one   (is_one),
    .is_unk   (is_unk),
    .is_err   (is_err),
    .is_nerr  (is_nerr),
    .ctrl_val (ctrl_val),
    .scan     (scan)
  );

  dgate_resolve u_resolve (
    .ctrl_scan  (scan),
    .ctrl_val   (ctrl_val),
    .inv_bit    (inv_bit),
    .out_lvl    (lvl_c),
    .fault_pass (pass_c)
  );

  if (REG_OUT) begin : g_reg
    lvl_e lvl_q, lvl_d;
    logic pass_q, pass_d;
    logic upd_en;

    assign upd_en = 1'b1;

    always_comb begin
      lvl_d  = lvl_q;
      pass_d = pass_q;
      if (upd_en) begin
        lvl_d  = lvl_c;
        pass_d = pass_c;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q  <= L_ZERO;
        pass_q <= 1'b0;
      end else begin
        lvl_q  <= lvl_d;
        pass_q <= pass_d;
      end
    end

    assign out_code = lvl_q;
    assign prop     = pass_q;

    // R9: registered result equals the evaluation of the previous edge
    a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_code == $past(lvl_c)));
    // R3: a controlling input forces c XOR i one cycle later
    a_r3_ctrl_forces: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(scan.has_ctrl)) |->
        (out_code == {2'b00, $past(ctrl_val ^ inv_bit)} && !prop));
    // R8: propagate flag only alongside a fault-effect output
    a_r8_prop_err: assert property (@(posedge clk) disable iff (!rst_n)
      prop |-> (out_code == L_ERR || out_code == L_NERR));
  end else begin : g_comb
    assign out_code = lvl_c;
    assign prop     = pass_c;
  end

endmodule

// File: tb/dgate_eval_bench.sv
module dgate_eval_bench;

  localparam int NI = 4;
  localparam int W  = NI * 3;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] in_codes;
  logic         ctrl_val;
  logic         inv_bit;
  logic [2:0]   out_code;
  logic         prop;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  dgate_eval u_dgate_eval (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_codes (in_codes),
    .ctrl_val (ctrl_val),
    .inv_bit  (inv_bit),
    .out_code (out_code),
    .prop     (prop)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference: evaluate good and faulty machines separately.
  function automatic logic [2:0] model(input logic [W-1:0] v, input logic c, input logic i);
    bit gc = 0, fc = 0, ux = 0, g = 0, f = 0, known;
    for (int k = 0; k < NI; k++) begin
      known = 1;
      case (v[k*3 +: 3])
        3'd0: begin g = 0; f = 0; end
        3'd1: begin g = 1; f = 1; end
        3'd3: begin g = 1; f = 0; end
        3'd4: begin g = 0; f = 1; end
        default: begin known = 0; ux = 1; end
      endcase
      if (known && g == c) gc = 1;
      if (known && f == c) fc = 1;
    end
    if (gc && fc) return {2'b00, c ^ i};
    if (ux) return 3'b010;
    g = (gc ? c : !c) ^ i;
    f = (fc ? c : !c) ^ i;
    case ({g, f})
      2'b00: return 3'b000;
      2'b11: return 3'b001;
      2'b10: return 3'b011;
      default: return 3'b100;
    endcase
  endfunction

  function automatic string tag_of(input logic [W-1:0] v, input logic c);
    bit ill = 0, ctl = 0, e = 0, ne = 0, x = 0, flt = 0;
    for (int k = 0; k < NI; k++) begin
      case (v[k*3 +: 3])
        3'd0: if (!c) ctl = 1;
        3'd1: if (c) ctl = 1;
        3'd2: x = 1;
        3'd3: e = 1;
        3'd4: ne = 1;
        default: ill = 1;
      endcase
    end
    flt = e | ne;
    if (ctl) return "R3";
    if (e && ne) return "R6";
    if (ill) return "R1";
    if (x) return "R7";
    if (flt) return "R5";
    return "R4";
  endfunction

  task automatic chk(input string tag, input logic [2:0] exp_c, input logic exp_p);
    checks++;
    if (out_code !== exp_c) begin
      errors++;
      $display("FAIL %s out_code actual=%0d expected=%0d", tag, out_code, exp_c);
    end
    checks++;
    if (prop !== exp_p) begin
      errors++;
      $display("FAIL R8 (%s) prop actual=%0b expected=%0b", tag, prop, exp_p);
    end
  endtask

  // Called at a negedge: drive, wait one edge, compare at next negedge.
  task automatic apply(input logic [W-1:0] v, input logic c, input logic i, input string pre);
    logic [2:0] e;
    in_codes = v; ctrl_val = c; inv_bit = i;
    e = model(v, c, i);
    @(negedge clk);
    chk({pre, tag_of(v, c)}, e, (e == 3'd3) || (e == 3'd4));
  endtask

  function automatic logic [W-1:0] pack4(input int a, input int b, input int cc, input int d);
    return {3'(d), 3'(cc), 3'(b), 3'(a)};
  endfunction

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] hold_c;
    logic       hold_p;
    rst_n = 1'b0; in_codes = pack4(3, 1, 1, 1); ctrl_val = 0; inv_bit = 0;
    repeat (3) @(negedge clk);
    chk("R9 reset", 3'd0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 first", 3'd3, 1'b1);

    // R2: all four gate types, E on one input, ideal side inputs
    for (int t = 0; t < 4; t++) begin
      logic c = t[0], i = t[1];
      int nc = c ? 0 : 1;
      for (int p = 0; p < NI; p++) begin
        logic [W-1:0] v = pack4(nc, nc, nc, nc);
        v[p*3 +: 3] = 3'd3;
        apply(v, c, i, "R2/");
        v[p*3 +: 3] = 3'd4;
        apply(v, c, i, "R2/");
        // spoil one side input at a time
        for (int q = 0; q < NI; q++) begin
          if (q != p) begin
            logic [W-1:0] s = v;
            for (int code = 0; code < 8; code++) begin
              s[q*3 +: 3] = 3'(code);
              apply(s, c, i, "R2/");
            end
          end
        end
      end
      apply(pack4(nc, nc, nc, nc), c, i, "R2/");        // R4
      apply(pack4(3, nc, 4, nc), c, i, "R2/");          // R6
      apply(pack4(2, nc, 7, 3), c, i, "R2/");           // R7 and R1
      apply(pack4(2, 5, 3, 32'(c)), c, i, "R2/");       // R3 over X
    end

    // R9: output holds until the next edge
    apply(pack4(3, 1, 1, 1), 0, 1, "R9/");
    hold_c = out_code; hold_p = prop;
    in_codes = pack4(0, 0, 0, 0);
    #1;
    chk("R9 hold", hold_c, hold_p);
    @(negedge clk);
    chk("R9 update", 3'd1, 1'b0);

    // Random, biased toward non-controlling and fault values
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] v;
      logic c = 1'($urandom_range(0, 1));
      logic i = 1'($urandom_range(0, 1));
      for (int k = 0; k < NI; k++) begin
        int r = $urandom_range(0, 15);
        if (r < 7) v[k*3 +: 3] = c ? 3'd0 : 3'd1;
        else if (r < 10) v[k*3 +: 3] = 3'($urandom_range(3, 4));
        else v[k*3 +: 3] = 3'($urandom_range(0, 7));
      end
      apply(v, c, i, "");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule